// File: doc/BRIEF.md
# Integer Execute Stage for a 64-bit Core

This block is the integer execute step of a 64-bit load/store core. Issue hands it the
decoded fields of one instruction (major opcode, the 10-bit middle field that carries
either an extension code with a second register index or a signed immediate, the
destination index and the 4 reserved low bits) together with both source operands and
the value the destination register holds now. One clock later it presents the value
to write back, a write strobe, the destination index and a flag for encodings it does
not accept.

The operations covered are a full-width add, two 32-bit adds whose sum is widened by
sign or by zero, immediate add in full and in 32-bit width, AND, AND-NOT and
AND-immediate, three compares that write 0 or 1, two conditional moves keyed on whether
the first operand is zero, and a byte-order swap. A conditional move whose condition
fails, or an unaccepted encoding, leaves the strobe low so the register file keeps its
old value.

Top module: `int_exec_unit`

## Requirements
- R1: While reset is asserted (active low), out_valid, out_wen, out_illegal, out_dst and out_data are all zero.
- R2: A cycle with issue_valid high gives out_valid high on the next cycle; a cycle with issue_valid low gives out_valid, out_wen and out_illegal low on the next cycle.
- R3: Opcode 0 with extension 9 (op_field[9:6]) writes src_a + src_b modulo 2^64; opcode 52 writes src_a plus op_field sign-extended from 10 bits.
- R4: Opcode 0 with extension 8 adds the low 32 bits of both operands and writes the 32-bit sum sign-extended; opcode 53 adds the low 32 bits of src_a and of the sign-extended immediate and writes that 32-bit sum sign-extended.
- R5: Opcode 0 with extension 12 writes the 32-bit sum of the low halves with its upper 32 bits zero.
- R6: Opcode 1 writes src_a & src_b for extension 11 and src_a & ~src_b for extension 15; opcode 54 writes src_a AND the sign-extended immediate.
- R7: Opcode 0 with extensions 1, 3 and 7 writes 1 when src_a equals src_b, is signed-greater than src_b, or is unsigned-greater than src_b respectively, and 0 otherwise; the strobe is high.
- R8: Opcode 8 with extension 1 writes src_b only when src_a is zero, with extension 5 only when src_a is nonzero; when the condition fails out_wen is low and out_data equals dst_old.
- R9: Opcode 0 with extension 15 and op_field[5:0] equal to 63 writes src_a with its eight bytes reversed (byte 0 to byte 7 and so on); any other value in op_field[5:0] makes it illegal.
- R10: Any nonzero op_rsvd, or any opcode/extension pair not listed in R3 to R9, sets out_illegal with out_wen low and out_data zero.
- R11: out_dst equals the op_dst presented in the issuing cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Reset, active low |
| issue_valid | input | 1 | An instruction is presented this cycle |
| op_code | input | 6 | Major opcode |
| op_field | input | 10 | Extension in [9:6] and second register index in [5:0], or signed immediate |
| op_dst | input | 6 | Destination register index |
| op_rsvd | input | 4 | Reserved bits, must be zero |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| dst_old | input | 64 | Present value of the destination register |
| out_valid | output | 1 | A result is presented |
| out_wen | output | 1 | Write the result to the destination |
| out_illegal | output | 1 | The encoding was not accepted |
| out_dst | output | 6 | Destination register index of the result |
| out_data | output | 64 | Result value |

## Verification
The hardest cases to reach are the ones where the same opcode and extension flip
between accepted and rejected on fields that ordinary traffic never disturbs: the byte
swap with a second register index other than 63, and otherwise valid encodings carrying
nonzero reserved bits. The stimulus sweeps all 1024 opcode/extension pairs, then
replays every accepted operation with the register index randomly forced to 63 or not
and with reserved bits set, while operands alternate between a zero first operand,
carry-into-bit-32 and sign-boundary patterns and pseudo-random values so that both
branches of each conditional move and each compare are taken.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

    localparam int OPC_W  = 6;
    localparam int FLD_W  = 10;
    localparam int EXT_W  = 4;
    localparam int RIDX_W = 6;
    localparam int RSV_W  = 4;

    // major opcodes
    localparam logic [OPC_W-1:0] OPC_ARITH = 6'd0;
    localparam logic [OPC_W-1:0] OPC_LOGIC = 6'd1;
    localparam logic [OPC_W-1:0] OPC_CMOVE = 6'd8;
    localparam logic [OPC_W-1:0] OPC_ADDI  = 6'd52;
    localparam logic [OPC_W-1:0] OPC_ADDIW = 6'd53;
    localparam logic [OPC_W-1:0] OPC_ANDI  = 6'd54;

    // extension codes under OPC_ARITH
    localparam logic [EXT_W-1:0] EXT_CMPEQ  = 4'd1;
    localparam logic [EXT_W-1:0] EXT_CMPGT  = 4'd3;
    localparam logic [EXT_W-1:0] EXT_CMPGTU = 4'd7;
    localparam logic [EXT_W-1:0] EXT_ADDWS  = 4'd8;
    localparam logic [EXT_W-1:0] EXT_ADD    = 4'd9;
    localparam logic [EXT_W-1:0] EXT_ADDWZ  = 4'd12;
    localparam logic [EXT_W-1:0] EXT_BSWAP  = 4'd15;
    // extension codes under OPC_LOGIC
    localparam logic [EXT_W-1:0] EXT_AND    = 4'd11;
    localparam logic [EXT_W-1:0] EXT_ANDN   = 4'd15;
    // extension codes under OPC_CMOVE
    localparam logic [EXT_W-1:0] EXT_MOVZ   = 4'd1;
    localparam logic [EXT_W-1:0] EXT_MOVNZ  = 4'd5;

    // second register index that a single-source form must carry
    localparam logic [RIDX_W-1:0] RIDX_NONE = 6'd63;

    typedef enum logic [3:0] {
        FN_BAD,
        FN_ADD,
        FN_ADDWS,
        FN_ADDWZ,
        FN_ADDI,
        FN_ADDIW,
        FN_AND,
        FN_ANDN,
        FN_ANDI,
        FN_CMPEQ,
        FN_CMPGT,
        FN_CMPGTU,
        FN_MOVZ,
        FN_MOVNZ,
        FN_BSWAP
    } exec_fn_e;

endpackage

// File: rtl/int_exec_decode.sv
module int_exec_decode
    import int_exec_pkg::*;
(
    input  logic [OPC_W-1:0] op_code,
    input  logic [FLD_W-1:0] op_field,
    input  logic [RSV_W-1:0] op_rsvd,
    output exec_fn_e         fn
);

    logic [EXT_W-1:0]  ext;
    logic [RIDX_W-1:0] ridx;

    assign ext  = op_field[FLD_W-1 -: EXT_W];
    assign ridx = op_field[RIDX_W-1:0];

    always_comb begin
        fn = FN_BAD;
        if (op_rsvd == '0) begin
            case (op_code)
                OPC_ARITH: begin
                    case (ext)
                        EXT_ADD:    fn = FN_ADD;
                        EXT_ADDWS:  fn = FN_ADDWS;
                        EXT_ADDWZ:  fn = FN_ADDWZ;
                        EXT_CMPEQ:  fn = FN_CMPEQ;
                        EXT_CMPGT:  fn = FN_CMPGT;
                        EXT_CMPGTU: fn = FN_CMPGTU;
                        EXT_BSWAP:  fn = (ridx == RIDX_NONE) ? FN_BSWAP : FN_BAD;
                        default:    fn = FN_BAD;
                    endcase
                end
                OPC_LOGIC: begin
                    case (ext)
                        EXT_AND:  fn = FN_AND;
                        EXT_ANDN: fn = FN_ANDN;
                        default:  fn = FN_BAD;
                    endcase
                end
                OPC_CMOVE: begin
                    case (ext)
                        EXT_MOVZ:  fn = FN_MOVZ;
                        EXT_MOVNZ: fn = FN_MOVNZ;
                        default:   fn = FN_BAD;
                    endcase
                end
                OPC_ADDI:  fn = FN_ADDI;
                OPC_ADDIW: fn = FN_ADDIW;
                OPC_ANDI:  fn = FN_ANDI;
                default:   fn = FN_BAD;
            endcase
        end
    end

endmodule

// File: rtl/int_exec_bswap.sv
module int_exec_bswap #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] din,
    output logic [XLEN-1:0] dout
);

    localparam int NBYTES = XLEN / 8;

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign dout[8*g +: 8] = din[8*(NBYTES-1-g) +: 8];
    end

endmodule

// File: rtl/int_exec_alu.sv
module int_exec_alu
    import int_exec_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  exec_fn_e         fn,
    input  logic [FLD_W-1:0] imm,
    input  logic [XLEN-1:0]  src_a,
    input  logic [XLEN-1:0]  src_b,
    input  logic [XLEN-1:0]  dst_old,
    output logic [XLEN-1:0]  result,
    output logic             wen,
    output logic             illegal
);

    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] imm_x;
    logic [XLEN-1:0] addend;
    logic [XLEN-1:0] sum;
    logic [HALF-1:0] sum_lo;
    logic [XLEN-1:0] swapped;
    logic            a_zero;
    logic            use_imm;

    assign imm_x   = {{(XLEN-FLD_W){imm[FLD_W-1]}}, imm};
    assign use_imm = (fn == FN_ADDI) || (fn == FN_ADDIW);
    assign addend  = use_imm ? imm_x : src_b;
    // one adder serves every add form; the low half is the 32-bit sum
    assign sum     = src_a + addend;
    assign sum_lo  = sum[HALF-1:0];
    assign a_zero  = (src_a == '0);

    int_exec_bswap #(.XLEN(XLEN)) u_bswap (
        .din  (src_a),
        .dout (swapped)
    );

    always_comb begin
        result  = '0;
        wen     = 1'b1;
        illegal = 1'b0;
        case (fn)
            FN_ADD, FN_ADDI:   result = sum;
            FN_ADDWS, FN_ADDIW: result = {{HALF{sum_lo[HALF-1]}}, sum_lo};
            FN_ADDWZ:          result = {{HALF{1'b0}}, sum_lo};
            FN_AND:            result = src_a & src_b;
            FN_ANDN:           result = src_a & ~src_b;
            FN_ANDI:           result = src_a & imm_x;
            FN_CMPEQ:          result = {{(XLEN-1){1'b0}}, src_a == src_b};
            FN_CMPGT:          result = {{(XLEN-1){1'b0}}, $signed(src_a) > $signed(src_b)};
            FN_CMPGTU:         result = {{(XLEN-1){1'b0}}, src_a > src_b};
            FN_MOVZ: begin
                wen    = a_zero;
                result = a_zero ? src_b : dst_old;
            end
            FN_MOVNZ: begin
                wen    = !a_zero;
                result = a_zero ? dst_old : src_b;
            end
            FN_BSWAP:          result = swapped;
            default: begin
                wen     = 1'b0;
                illegal = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import int_exec_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [5:0]        op_code,
    input  logic [9:0]        op_field,
    input  logic [5:0]        op_dst,
    input  logic [3:0]        op_rsvd,
    input  logic [XLEN-1:0]   src_a,
    input  logic [XLEN-1:0]   src_b,
    input  logic [XLEN-1:0]   dst_old,
    output logic              out_valid,
    output logic              out_wen,
    output logic              out_illegal,
    output logic [5:0]        out_dst,
    output logic [XLEN-1:0]   out_data
);

    typedef struct packed {
        logic              valid;
        logic              wen;
        logic              illegal;
        logic [RIDX_W-1:0] dst;
        logic [XLEN-1:0]   data;
    } stage_t;

    exec_fn_e        fn;
    logic [XLEN-1:0] alu_res;
    logic            alu_wen;
    logic            alu_ill;
    stage_t          st_d;
    stage_t          st_q;

    int_exec_decode u_dec (
        .op_code  (op_code),
        .op_field (op_field),
        .op_rsvd  (op_rsvd),
        .fn       (fn)
    );

    int_exec_alu #(.XLEN(XLEN)) u_alu (
        .fn      (fn),
        .imm     (op_field),
        .src_a   (src_a),
        .src_b   (src_b),
        .dst_old (dst_old),
        .result  (alu_res),
        .wen     (alu_wen),
        .illegal (alu_ill)
    );

    always_comb begin
        st_d = '0;
        if (issue_valid) begin
            st_d.valid   = 1'b1;
            st_d.wen     = alu_wen;
            st_d.illegal = alu_ill;
            st_d.dst     = op_dst;
            st_d.data    = alu_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.valid;
    assign out_wen     = st_q.wen;
    assign out_illegal = st_q.illegal;
    assign out_dst     = st_q.dst;
    assign out_data    = st_q.data;

endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            issue_valid,
    input logic [5:0]      op_code,
    input logic [9:0]      op_field,
    input logic [5:0]      op_dst,
    input logic [3:0]      op_rsvd,
    input logic [XLEN-1:0] dst_old,
    input logic            out_valid,
    input logic            out_wen,
    input logic            out_illegal,
    input logic [5:0]      out_dst,
    input logic [XLEN-1:0] out_data
);

    localparam int HALF = XLEN / 2;

    logic [3:0] ext;
    logic       is_cmp;
    logic       is_zext;
    assign ext     = op_field[9:6];
    assign is_cmp  = issue_valid && (op_code == 6'd0) && (op_rsvd == 4'd0)
                     && ((ext == 4'd1) || (ext == 4'd3) || (ext == 4'd7));
    assign is_zext = issue_valid && (op_code == 6'd0) && (op_rsvd == 4'd0) && (ext == 4'd12);

    assert_issue_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> out_valid);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> (!out_valid && !out_wen && !out_illegal));

    assert_dst_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> (out_dst == $past(op_dst)));

    assert_illegal_nowrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (!out_wen && out_data == '0));

    assert_rsvd_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && op_rsvd != 4'd0) |=> out_illegal);

    assert_cmp_boolean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmp |=> (out_wen && out_data[XLEN-1:1] == '0));

    assert_zext_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
        is_zext |=> (out_data[XLEN-1:HALF] == '0));

    assert_cmove_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_wen && !out_illegal) |-> (out_data == $past(dst_old)));

endmodule

bind int_exec_unit int_exec_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .op_code     (op_code),
    .op_field    (op_field),
    .op_dst      (op_dst),
    .op_rsvd     (op_rsvd),
    .dst_old     (dst_old),
    .out_valid   (out_valid),
    .out_wen     (out_wen),
    .out_illegal (out_illegal),
    .out_dst     (out_dst),
    .out_data    (out_data)
);

// File: tb/int_exec_unit_test.sv
`timescale 1ns/1ps
module int_exec_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [5:0]  op_code = '0;
    logic [9:0]  op_field = '0;
    logic [5:0]  op_dst = '0;
    logic [3:0]  op_rsvd = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [63:0] dst_old = '0;
    logic        out_valid;
    logic        out_wen;
    logic        out_illegal;
    logic [5:0]  out_dst;
    logic [63:0] out_data;

    int checks = 0;
    int failures = 0;
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    always #2.5 clk = ~clk;

    int_exec_unit #(.XLEN(64)) uut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
        .op_code(op_code), .op_field(op_field), .op_dst(op_dst), .op_rsvd(op_rsvd),
        .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
        .out_valid(out_valid), .out_wen(out_wen), .out_illegal(out_illegal),
        .out_dst(out_dst), .out_data(out_data)
    );

    function automatic logic [63:0] next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 7);
        rng = rng ^ (rng << 17);
        return rng;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] sx10(input logic [9:0] v);
        return {{54{v[9]}}, v};
    endfunction

    // reference model written from the requirement list
    task automatic model(input logic [5:0] opc, input logic [9:0] fld, input logic [3:0] rsv,
                         input logic [63:0] a, input logic [63:0] b, input logic [63:0] dc,
                         output logic [63:0] d, output logic w, output logic il,
                         output string req);
        logic [3:0]  ext;
        logic [31:0] s32;
        ext = fld[9:6];
        d = 64'd0; w = 1'b1; il = 1'b0; req = "R10";
        if (rsv != 4'd0) begin
            w = 1'b0; il = 1'b1;
        end else if (opc == 6'd0 && ext == 4'd9) begin
            d = a + b; req = "R3";
        end else if (opc == 6'd52) begin
            d = a + sx10(fld); req = "R3";
        end else if (opc == 6'd0 && ext == 4'd8) begin
            s32 = a[31:0] + b[31:0]; d = {{32{s32[31]}}, s32}; req = "R4";
        end else if (opc == 6'd53) begin
            s32 = a[31:0] + sx10(fld)[31:0]; d = {{32{s32[31]}}, s32}; req = "R4";
        end else if (opc == 6'd0 && ext == 4'd12) begin
            s32 = a[31:0] + b[31:0]; d = {32'd0, s32}; req = "R5";
        end else if (opc == 6'd1 && ext == 4'd11) begin
            d = a & b; req = "R6";
        end else if (opc == 6'd1 && ext == 4'd15) begin
            d = a & ~b; req = "R6";
        end else if (opc == 6'd54) begin
            d = a & sx10(fld); req = "R6";
        end else if (opc == 6'd0 && ext == 4'd1) begin
            d = (a == b) ? 64'd1 : 64'd0; req = "R7";
        end else if (opc == 6'd0 && ext == 4'd3) begin
            d = ($signed(a) > $signed(b)) ? 64'd1 : 64'd0; req = "R7";
        end else if (opc == 6'd0 && ext == 4'd7) begin
            d = (a > b) ? 64'd1 : 64'd0; req = "R7";
        end else if (opc == 6'd8 && (ext == 4'd1 || ext == 4'd5)) begin
            req = "R8";
            w = (ext == 4'd1) ? (a == 64'd0) : (a != 64'd0);
            d = w ? b : dc;
        end else if (opc == 6'd0 && ext == 4'd15) begin
            req = "R9";
            if (fld[5:0] == 6'd63) begin
                for (int i = 0; i < 8; i++) d[8*i +: 8] = a[8*(7-i) +: 8];
            end else begin
                w = 1'b0; il = 1'b1;
            end
        end else begin
            w = 1'b0; il = 1'b1;
        end
    endtask

    task automatic run_op(input logic [5:0] opc, input logic [9:0] fld, input logic [3:0] rsv,
                          input logic [63:0] a, input logic [63:0] b);
        logic [63:0] ed;
        logic        ew;
        logic        eil;
        logic [63:0] dc;
        logic [5:0]  dst;
        string       req;
        dc  = next_rand();
        dst = next_rand()[5:0];
        @(negedge clk);
        issue_valid = 1'b1; op_code = opc; op_field = fld; op_rsvd = rsv;
        op_dst = dst; src_a = a; src_b = b; dst_old = dc;
        model(opc, fld, rsv, a, b, dc, ed, ew, eil, req);
        @(negedge clk);
        check("R2", "valid", {63'd0, out_valid}, 64'd1);
        check(req, "illegal", {63'd0, out_illegal}, {63'd0, eil});
        check(req, "wen", {63'd0, out_wen}, {63'd0, ew});
        check(req, "data", out_data, ed);
        check("R11", "dst", {58'd0, out_dst}, {58'd0, dst});
    endtask

    function automatic logic [63:0] pattern(input int k);
        case (k % 8)
            0: return 64'd0;
            1: return 64'hFFFF_FFFF_FFFF_FFFF;
            2: return 64'h0000_0000_7FFF_FFFF;
            3: return 64'h8000_0000_0000_0000;
            4: return 64'h7FFF_FFFF_FFFF_FFFF;
            5: return 64'h0000_0000_FFFF_FFFF;
            6: return 64'h0000_0000_0000_0001;
            default: return 64'h0123_4567_89AB_CDEF;
        endcase
    endfunction

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "valid", {63'd0, out_valid}, 64'd0);
        check("R1", "wen", {63'd0, out_wen}, 64'd0);
        check("R1", "illegal", {63'd0, out_illegal}, 64'd0);
        check("R1", "dst", {58'd0, out_dst}, 64'd0);
        check("R1", "data", out_data, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2", "idle valid", {63'd0, out_valid}, 64'd0);

        // R10: sweep every opcode/extension pair, second index 63
        for (int op = 0; op < 64; op++) begin
            for (int ex = 0; ex < 16; ex++) begin
                run_op(op[5:0], {ex[3:0], 6'd63}, 4'd0, next_rand(), next_rand());
            end
        end

        // operand patterns over every accepted operation
        for (int j = 0; j < 120; j++) begin
            for (int k = 0; k < 14; k++) begin
                logic [5:0]  opc;
                logic [3:0]  ext;
                logic [9:0]  fld;
                logic [63:0] a;
                logic [63:0] b;
                logic [63:0] r;
                case (k)
                    0: begin opc = 6'd0; ext = 4'd9; end
                    1: begin opc = 6'd0; ext = 4'd8; end
                    2: begin opc = 6'd0; ext = 4'd12; end
                    3: begin opc = 6'd52; ext = 4'd0; end
                    4: begin opc = 6'd53; ext = 4'd0; end
                    5: begin opc = 6'd1; ext = 4'd11; end
                    6: begin opc = 6'd1; ext = 4'd15; end
                    7: begin opc = 6'd54; ext = 4'd0; end
                    8: begin opc = 6'd0; ext = 4'd1; end
                    9: begin opc = 6'd0; ext = 4'd3; end
                    10: begin opc = 6'd0; ext = 4'd7; end
                    11: begin opc = 6'd8; ext = 4'd1; end
                    12: begin opc = 6'd8; ext = 4'd5; end
                    default: begin opc = 6'd0; ext = 4'd15; end
                endcase
                r = next_rand();
                if (opc >= 6'd52) fld = r[9:0];
                else fld = {ext, r[10] ? 6'd63 : r[5:0]};
                if (j < 64) begin
                    a = pattern(j); b = pattern(j / 8);
                end else begin
                    a = (j % 5 == 0) ? 64'd0 : next_rand();
                    b = (j % 7 == 0) ? a : next_rand();
                end
                run_op(opc, fld, (j % 9 == 4) ? r[15:12] | 4'd1 : 4'd0, a, b);
            end
        end

        // R9: byte swap of a known value, and a rejected second index
        run_op(6'd0, {4'd15, 6'd63}, 4'd0, 64'h0011_2233_4455_6677, 64'd0);
        check("R9", "swap value", out_data, 64'h7766_5544_3322_1100);
        run_op(6'd0, {4'd15, 6'd62}, 4'd0, 64'h0011_2233_4455_6677, 64'd0);
        check("R9", "bad index rejected", {63'd0, out_illegal}, 64'd1);

        // R8: failing move keeps old destination, no write
        run_op(6'd8, {4'd5, 6'd3}, 4'd0, 64'd0, 64'hDEAD_BEEF);
        check("R8", "no write", {63'd0, out_wen}, 64'd0);

        // R2: idle cycle after traffic
        @(negedge clk);
        issue_valid = 1'b0;
        @(negedge clk);
        check("R2", "idle valid", {63'd0, out_valid}, 64'd0);
        check("R2", "idle wen", {63'd0, out_wen}, 64'd0);
        check("R2", "idle illegal", {63'd0, out_illegal}, 64'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule